// File: doc/BRIEF.md
# RGB to YCbCr Matrix Converter

This block turns a stream of 10-bit RGB pixels into 10-bit YCbCr pixels with a fixed 3x3 weighting matrix. Luma is a positive weighted sum of the three inputs. Each of the two colour-difference channels is a signed weighted sum plus a mid-scale offset, so a colourless input lands in the middle of the code range. The matrix uses its own coefficient set. It is not the textbook BT.601 matrix: its blue weight for Cb and its red weight for Cr are both 0.511.

A pixel is presented on `in_r`/`in_g`/`in_b` together with `in_valid`. The converted pixel appears exactly two clock cycles later, qualified by `out_valid`. A new pixel may be accepted on every cycle, and gaps in the input stream pass through as gaps in the output stream. The coefficients are signed fixed-point constants with 12 fractional bits. Every channel is rounded to the nearest integer and clamped to the 10-bit range.

Top module: `csc_rgb2ycc`

## Requirements
- R1: Luma uses Q12 weights 1225 (red), 2404 (green) and 467 (blue) with no offset.
- R2: Cb uses Q12 weights -705 (red), -1389 (green) and 2093 (blue), and a mid-scale offset of 512 is added.
- R3: Cr uses Q12 weights 2093 (red), -1753 (green) and -340 (blue), and a mid-scale offset of 512 is added.
- R4: Rounding adds 2048 to the scaled sum (weighted sum plus offset times 4096) and then takes the floor after dividing by 4096, so exact halves go upward.
- R5: A channel result below 0 is output as 0.
- R6: A channel result above 1023 is output as 1023.
- R7: A pixel sampled with `in_valid` high at a clock edge produces `out_valid` high with its converted value two rising edges later.
- R8: While `rst` is high at a rising edge, the pipeline valid bits clear. `out_valid` stays low until two edges after the first valid pixel accepted once reset is released.
- R9: A gray input (red = green = blue = x) gives Y = x and Cb = Cr = 512.
- R10: A cycle with `in_valid` low produces a cycle with `out_valid` low two edges later, whatever the data inputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Input pixel qualifier |
| in_r | input | 10 | Red component, unsigned |
| in_g | input | 10 | Green component, unsigned |
| in_b | input | 10 | Blue component, unsigned |
| out_valid | output | 1 | Output pixel qualifier |
| out_y | output | 10 | Luma result |
| out_cb | output | 10 | Blue colour-difference result |
| out_cr | output | 10 | Red colour-difference result |

## Verification
The bench builds the block with the default package values: 10-bit samples and 12 fractional coefficient bits. With those values the chroma channels overshoot the code range at full-scale primaries, because the blue weight of Cb plus the offset reaches about 1035, so both clamps are reached by directed corner pixels. The luma weights add up to exactly 4096, so gray inputs map to themselves. The Cb weights add up to -1, which checks that the rounding step hides that bias. Random pixels with random valid gaps exercise the rounding step and the bubble handling. A reset applied while the pipe is full covers the clearing of the valid bits.

// File: rtl/csc_pkg.sv
package csc_pkg;

    localparam int PIX_W  = 10;
    localparam int FRAC_W = 12;
    localparam int NUM_CH = 3;
    localparam int ACC_W  = PIX_W + FRAC_W + 4;
    localparam int PIX_MAX = (1 << PIX_W) - 1;
    localparam int PIX_MID = 1 << (PIX_W - 1);

    typedef logic [PIX_W-1:0]        pix_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef enum int {
        CH_LUMA = 0,
        CH_BDIF = 1,
        CH_RDIF = 2
    } chan_e;

    typedef struct packed {
        pix_t red;
        pix_t grn;
        pix_t blu;
    } rgb_pix_t;

    typedef struct packed {
        pix_t luma;
        pix_t bdif;
        pix_t rdif;
    } ycc_pix_t;

    // Weights in thousandths; index k selects red, green, blue.
    function automatic int weight_milli(input int ch, input int k);
        int w;
        w = 0;
        case (ch)
            CH_LUMA: w = (k == 0) ? 299  : (k == 1) ? 587  : 114;
            CH_BDIF: w = (k == 0) ? -172 : (k == 1) ? -339 : 511;
            default: w = (k == 0) ? 511  : (k == 1) ? -428 : -83;
        endcase
        return w;
    endfunction

    // Quantise a weight to FRAC_W fractional bits, rounding to nearest.
    function automatic int weight_q(input int ch, input int k);
        int m;
        m = weight_milli(ch, k);
        if (m >= 0)
            return ((m << FRAC_W) + 500) / 1000;
        else
            return -((((-m) << FRAC_W) + 500) / 1000);
    endfunction

    function automatic int chan_offset(input int ch);
        return (ch == CH_LUMA) ? 0 : PIX_MID;
    endfunction

endpackage

// File: rtl/csc_dot_stage.sv
module csc_dot_stage
    import csc_pkg::*;
#(
    parameter int K_RED = 0,
    parameter int K_GRN = 0,
    parameter int K_BLU = 0
) (
    input  logic     clk,
    input  rgb_pix_t pix_i,
    output acc_t     sum_o
);

    localparam acc_t KR = acc_t'(K_RED);
    localparam acc_t KG = acc_t'(K_GRN);
    localparam acc_t KB = acc_t'(K_BLU);

    acc_t xr, xg, xb;
    acc_t dot;

    always_comb begin
        xr  = acc_t'(pix_i.red);
        xg  = acc_t'(pix_i.grn);
        xb  = acc_t'(pix_i.blu);
        dot = (KR * xr) + (KG * xg) + (KB * xb);
    end

    always_ff @(posedge clk) begin
        sum_o <= dot;
    end

endmodule

// File: rtl/csc_round_stage.sv
module csc_round_stage
    import csc_pkg::*;
#(
    parameter int OFFSET = 0
) (
    input  logic clk,
    input  logic rst,
    input  acc_t sum_i,
    output pix_t res_o
);

    localparam int   HALF = 1 << (FRAC_W - 1);
    localparam acc_t BIAS = acc_t'((OFFSET << FRAC_W) + HALF);
    localparam acc_t TOP  = acc_t'(PIX_MAX);

    acc_t biased;
    acc_t scaled;
    pix_t clamped;

    always_comb begin
        biased = sum_i + BIAS;
        scaled = biased >>> FRAC_W;
        if (scaled < 0)
            clamped = '0;
        else if (scaled > TOP)
            clamped = pix_t'(PIX_MAX);
        else
            clamped = scaled[PIX_W-1:0];
    end

    always_ff @(posedge clk) begin
        res_o <= clamped;
    end

    AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (rst)
        (sum_i + BIAS < 0) |=> (res_o == '0)); // R5

    AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sum_i + BIAS >= ((TOP + 1) <<< FRAC_W)) |=> (res_o == pix_t'(PIX_MAX))); // R6

endmodule

// File: rtl/csc_rgb2ycc.sv
module csc_rgb2ycc
    import csc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_r,
    input  logic [PIX_W-1:0] in_g,
    input  logic [PIX_W-1:0] in_b,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_y,
    output logic [PIX_W-1:0] out_cb,
    output logic [PIX_W-1:0] out_cr
);

    rgb_pix_t pix_in;
    ycc_pix_t pix_out;
    acc_t     ch_sum [NUM_CH];
    pix_t     ch_res [NUM_CH];
    logic     vld_s1;

    assign pix_in = '{red: in_r, grn: in_g, blu: in_b};

    for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_chan
        csc_dot_stage #(
            .K_RED (weight_q(gc, 0)),
            .K_GRN (weight_q(gc, 1)),
            .K_BLU (weight_q(gc, 2))
        ) u_dot (
            .clk   (clk),
            .pix_i (pix_in),
            .sum_o (ch_sum[gc])
        );

        csc_round_stage #(
            .OFFSET (chan_offset(gc))
        ) u_round (
            .clk   (clk),
            .rst   (rst),
            .sum_i (ch_sum[gc]),
            .res_o (ch_res[gc])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_s1    <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            vld_s1    <= in_valid;
            out_valid <= vld_s1;
        end
    end

    assign pix_out = '{luma: ch_res[CH_LUMA], bdif: ch_res[CH_BDIF], rdif: ch_res[CH_RDIF]};
    assign out_y   = pix_out.luma;
    assign out_cb  = pix_out.bdif;
    assign out_cr  = pix_out.rdif;

    AST_VALID_STAGE1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> vld_s1); // R7

    AST_VALID_STAGE2: assert property (@(posedge clk) disable iff (rst)
        vld_s1 |=> out_valid); // R7

    AST_BUBBLE_KEPT: assert property (@(posedge clk) disable iff (rst)
        !vld_s1 |=> !out_valid); // R10

    AST_GRAY_PASS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_r, 2) == $past(in_g, 2) && $past(in_g, 2) == $past(in_b, 2))
        |-> (out_y == $past(in_r, 2) && out_cb == pix_t'(PIX_MID) && out_cr == pix_t'(PIX_MID))); // R9

endmodule

// File: tb/csc_rgb2ycc_tb_top.sv
module csc_rgb2ycc_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [9:0] in_r, in_g, in_b;
    logic       out_valid;
    logic [9:0] out_y, out_cb, out_cr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // two-deep history of applied stimulus: [0] last negedge, [1] the one before
    int h_v[2];
    int h_r[2];
    int h_g[2];
    int h_b[2];

    always #(CLK_PERIOD/2) clk = ~clk;

    csc_rgb2ycc dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_r      (in_r),
        .in_g      (in_g),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_y     (out_y),
        .out_cb    (out_cb),
        .out_cr    (out_cr)
    );

    // Behavioural model of one channel from R1..R6.
    function automatic int model(input int ch, input int r, input int g, input int b);
        int acc;
        int q;
        case (ch)
            0: acc = 1225*r + 2404*g + 467*b;                  // R1
            1: acc = -705*r - 1389*g + 2093*b + 512*4096;      // R2
            default: acc = 2093*r - 1753*g - 340*b + 512*4096; // R3
        endcase
        q = (acc + 2048) >>> 12;                               // R4
        if (q < 0) q = 0;                                      // R5
        if (q > 1023) q = 1023;                                // R6
        return q;
    endfunction

    task automatic check(input string req, input int act, input int exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
        end
    endtask

    // One cycle: compare outputs against the pixel applied two negedges ago, then drive.
    task automatic step(input bit r_rst, input bit v, input int r, input int g, input int b,
                        input string vreq);
        @(negedge clk);
        if (out_valid === 1'bx) check(vreq, 2, h_v[1]);
        else check(vreq, int'(out_valid), h_v[1]);
        if (h_v[1] != 0 && out_valid === 1'b1) begin
            check("R1", int'(out_y),  model(0, h_r[1], h_g[1], h_b[1]));
            check("R2", int'(out_cb), model(1, h_r[1], h_g[1], h_b[1]));
            check("R3", int'(out_cr), model(2, h_r[1], h_g[1], h_b[1]));
        end
        h_v[1] = r_rst ? 0 : h_v[0];
        h_r[1] = h_r[0]; h_g[1] = h_g[0]; h_b[1] = h_b[0];
        h_v[0] = r_rst ? 0 : int'(v);
        h_r[0] = r; h_g[0] = g; h_b[0] = b;
        rst      = r_rst;
        in_valid = v;
        in_r     = r[9:0];
        in_g     = g[9:0];
        in_b     = b[9:0];
    endtask

    task automatic pix(input int r, input int g, input int b);
        step(1'b0, 1'b1, r, g, b, "R7");
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_r = '0; in_g = '0; in_b = '0;
        for (int i = 0; i < 2; i++) begin
            h_v[i] = 0; h_r[i] = 0; h_g[i] = 0; h_b[i] = 0;
        end
        repeat (2) @(posedge clk);

        // R8: valid inputs during reset must not come out
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 100 + i, 200, 300, "R8");
        step(1'b0, 1'b0, 0, 0, 0, "R8");
        step(1'b0, 1'b0, 0, 0, 0, "R8");

        // extremes: black, white, primaries (R5, R6 on chroma)
        pix(0, 0, 0);
        pix(1023, 1023, 1023);
        pix(0, 0, 1023);      // Cb above range -> 1023 (R6)
        pix(1023, 1023, 0);   // Cb below range -> 0 (R5)
        pix(1023, 0, 0);      // Cr above range -> 1023 (R6)
        pix(0, 1023, 1023);   // Cr below range -> 0 (R5)
        pix(0, 1023, 0);
        // gray inputs map to themselves (R9)
        pix(5, 5, 5);
        pix(100, 100, 100);
        pix(512, 512, 512);
        pix(1000, 1000, 1000);
        // small values exercise the rounding step (R4)
        pix(1, 0, 0);
        pix(2, 0, 0);
        pix(0, 1, 0);
        pix(0, 0, 1);
        pix(3, 7, 11);

        // bubbles with busy data inputs must stay invalid (R10)
        for (int i = 0; i < 12; i++)
            step(1'b0, (i % 2) == 0, 37*i, 1023 - 41*i, 300 + 9*i, "R10");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 999, 888, 777, "R10");

        // random stream with random gaps (R1..R4, R7, R10)
        for (int i = 0; i < 600; i++)
            step(1'b0, ($urandom % 4) != 0, $urandom % 1024, $urandom % 1024,
                 $urandom % 1024, "R7");

        // reset with the pipe full clears valid bits (R8)
        pix(10, 20, 30);
        pix(40, 50, 60);
        step(1'b1, 1'b1, 70, 80, 90, "R8");
        step(1'b0, 1'b0, 0, 0, 0, "R8");
        step(1'b0, 1'b0, 0, 0, 0, "R8");
        pix(700, 300, 100);
        pix(100, 300, 700);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 0, 0, 0, "R7");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule